// File: doc/BRIEF.md
# Receive Reset Sequencer for Serial Transceiver Lanes

This block sequences the receive-side reset of one multi-gigabit serial lane or of a group of channel-bonded lanes. Each lane reports a PLL lock indication. In analog clock-recovery mode that indication first rises when the PLL locks to the reference clock. Without usable line data it then falls again, anywhere between a hundred-odd and sixteen thousand reference cycles later, and the pattern repeats. Only a lock that stays up for a long, unbroken stretch shows that the loop has locked to the incoming data. The sequencer holds the lanes in reset until every monitored lock has been continuously high for `QUAL_CYCLES` reference-clock cycles (16K by default). It then releases them.

In digital clock-recovery mode the PLL never leaves the reference clock, so the long wait is skipped and a short, two-sample confirmation is enough. Every lock input is synchronized into the reference-clock domain. Lock qualification and the sequencing state machine run there. No logic depends on the recovered clock, which is frozen while the receiver is in reset. The release decision then crosses into the user clock domain. For narrow data widths (1 or 2 bytes), a single registered bit there drives every bonded lane's reset, so all lanes leave reset on the same user-clock edge. For wide data widths (4 bytes and more), each lane is released as soon as its own lock qualifies. If lock is lost after the sequence completes, the ready flag drops and qualification starts over.

Top module: `rxrst_seq`

## Requirements
- R1: While `sys_rst_n` is low, and after it is released until qualification completes, every bit of `rx_reset` is 1 and `ready` is 0.
- R2: Each `lane_lock` bit passes through a two-stage synchronizer on `ref_clk`. With both clocks on one net, `ready` rises on the 6th `ref_clk` edge after the edge at which the qualification condition is first met. That condition is R3 in analog mode and R6 in digital mode.
- R3: In analog mode (`digital_mode`=0), release requires all `lane_lock` bits to be sampled high on `QUAL_CYCLES`+1 consecutive edges. A lock that holds for exactly `QUAL_CYCLES` samples and then falls, or one that falls after 128 samples, never releases reset.
- R4: When any lane's lock falls during qualification, the count restarts from zero once the lock returns. Release then needs a full new window measured from the return.
- R5: When `wide_data`=0 (1- or 2-byte width), all `rx_reset` bits always hold the same value and fall on the same `usr_clk` edge as `ready` rises.
- R6: In digital mode (`digital_mode`=1), the long wait is skipped: two consecutive high samples on all lanes qualify the lock.
- R7: After `ready` is high, a low lock sample on any lane makes `ready` fall and every `rx_reset` bit rise 6 edges later (`wide_data`=0), and the sequencer returns to waiting for lock.
- R8: When `wide_data`=1 (4-byte or wider), lane i's `rx_reset` bit falls 5 edges after that lane alone meets the R3 or R6 condition, independent of the other lanes. `ready` still follows the whole group as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; lock qualification runs here |
| usr_clk | input | 1 | Receive user clock; reset release is registered here |
| sys_rst_n | input | 1 | Asynchronous system reset, active low |
| lane_lock | input | NUM_LANES | Per-lane PLL lock indication, asynchronous |
| digital_mode | input | 1 | 1 = digital clock recovery, 0 = analog clock recovery |
| wide_data | input | 1 | 1 = 4-byte or wider data, lanes released independently; 0 = 1/2-byte, lockstep release |
| rx_reset | output | NUM_LANES | Per-lane receive reset, active high |
| ready | output | 1 | The whole group has qualified lock and left reset |

## Verification
The assertions assume that `digital_mode` and `wide_data` are quasi-static. Both may change only while `sys_rst_n` is low, because they are read without synchronization in both clock domains. The stimulus changes the mode pins only inside a reset pulse. It drives the lock inputs away from the active edge and ties both clocks to one net, which makes the crossing latency deterministic. Lock waveforms cover a drop after 128 cycles, a hold of exactly the qualification length followed by a drop, a lane glitch during qualification, lock loss after completion, and staggered per-lane locking in wide mode.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [1:0] {
    ST_ASSERT_RESET = 2'd0,
    ST_WAIT_LOCK    = 2'd1,
    ST_QUALIFY_LOCK = 2'd2,
    ST_DONE         = 2'd3
  } seq_state_t;

  // Number of counted lock cycles that qualify a lane.
  function automatic int qual_limit(input logic digital, input int full_count);
    return digital ? 1 : full_count;
  endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RESET_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rxrst_lane_qual.sv
module rxrst_lane_qual import rxrst_pkg::*; #(
  parameter int QUAL_CYCLES = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic digital_mode,
  output logic qual,
  output logic cnt_full
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!lock_s)      cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign cnt_full = (cnt == CNT_MAX);
  assign qual     = lock_s && (int'(cnt) >= qual_limit(digital_mode, QUAL_CYCLES));
endmodule

// File: rtl/rxrst_fsm.sv
module rxrst_fsm import rxrst_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       all_lock,
  input  logic       all_qual,
  output seq_state_t state,
  output logic       evt_enter_done,
  output logic       evt_restart,
  output logic       evt_lock_lost
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_ASSERT_RESET: nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK:    if (all_lock) nxt = ST_QUALIFY_LOCK;
      ST_QUALIFY_LOCK: begin
        if (!all_lock)     nxt = ST_WAIT_LOCK;
        else if (all_qual) nxt = ST_DONE;
      end
      ST_DONE:         if (!all_lock) nxt = ST_WAIT_LOCK;
      default:         nxt = ST_ASSERT_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ASSERT_RESET;
    else        state <= nxt;
  end

  assign evt_enter_done = (state == ST_QUALIFY_LOCK) && (nxt == ST_DONE);
  assign evt_restart    = (state == ST_QUALIFY_LOCK) && !all_lock;
  assign evt_lock_lost  = (state == ST_DONE) && !all_lock;
endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq import rxrst_pkg::*; #(
  parameter int NUM_LANES   = 4,
  parameter int QUAL_CYCLES = 16384,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 ref_clk,
  input  logic                 usr_clk,
  input  logic                 sys_rst_n,
  input  logic [NUM_LANES-1:0] lane_lock,
  input  logic                 digital_mode,
  input  logic                 wide_data,
  output logic [NUM_LANES-1:0] rx_reset,
  output logic                 ready
);
  localparam int XW = NUM_LANES + 1;   // lane release bits plus group-done bit

  // ---------------- reference-clock domain ----------------
  logic [NUM_LANES-1:0] lock_s;
  logic [NUM_LANES-1:0] lane_qual;
  logic [NUM_LANES-1:0] lane_full;
  logic                 all_lock, all_qual, all_full;
  seq_state_t           state;
  logic                 evt_enter_done, evt_restart, evt_lock_lost;
  logic [NUM_LANES-1:0] lane_rel_q;
  logic                 done_q;

  rxrst_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(ref_clk), .rst_n(sys_rst_n), .d(lane_lock), .q(lock_s)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rxrst_lane_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk(ref_clk), .rst_n(sys_rst_n), .lock_s(lock_s[g]),
      .digital_mode(digital_mode), .qual(lane_qual[g]), .cnt_full(lane_full[g])
    );
  end

  assign all_lock = &lock_s;
  assign all_qual = &lane_qual;
  assign all_full = &lane_full;

  rxrst_fsm u_fsm (
    .clk(ref_clk), .rst_n(sys_rst_n), .all_lock(all_lock), .all_qual(all_qual),
    .state(state), .evt_enter_done(evt_enter_done),
    .evt_restart(evt_restart), .evt_lock_lost(evt_lock_lost)
  );

  // Registered release requests: glitch-free sources for the crossing.
  always_ff @(posedge ref_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      lane_rel_q <= '0;
      done_q     <= 1'b0;
    end else begin
      lane_rel_q <= lane_qual;
      done_q     <= (state == ST_DONE);
    end
  end

  // ---------------- user-clock domain ----------------
  logic [XW-1:0] rel_s;

  rxrst_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_rel_sync (
    .clk(usr_clk), .rst_n(sys_rst_n), .d({done_q, lane_rel_q}), .q(rel_s)
  );

  // A single synchronized done bit feeds every lane in narrow mode.
  always_ff @(posedge usr_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rx_reset <= '1;
      ready    <= 1'b0;
    end else begin
      rx_reset <= wide_data ? ~rel_s[NUM_LANES-1:0] : {NUM_LANES{~rel_s[NUM_LANES]}};
      ready    <= rel_s[NUM_LANES];
    end
  end
endmodule

// File: rtl/rxrst_seq_chk.sv
module rxrst_seq_chk import rxrst_pkg::*; #(
  parameter int NUM_LANES = 4
) (
  input logic                 ref_clk,
  input logic                 usr_clk,
  input logic                 sys_rst_n,
  input logic                 digital_mode,
  input logic                 wide_data,
  input seq_state_t           state,
  input logic                 all_full,
  input logic                 evt_enter_done,
  input logic                 evt_restart,
  input logic                 evt_lock_lost,
  input logic [NUM_LANES-1:0] rx_reset,
  input logic                 ready
);
  AST_QUAL_FULL: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    (evt_enter_done && !digital_mode) |-> all_full); // R3

  AST_QUAL_RESTART: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    evt_restart |=> (!all_full && state == ST_WAIT_LOCK)); // R4

  AST_LOSS_REARM: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    evt_lock_lost |=> (state == ST_WAIT_LOCK && !all_full)); // R7

  AST_LOCKSTEP: assert property (@(posedge usr_clk) disable iff (!sys_rst_n)
    !wide_data |-> (rx_reset == '0 || rx_reset == '1)); // R5

  AST_READY_RELEASED: assert property (@(posedge usr_clk) disable iff (!sys_rst_n)
    (!wide_data && ready) |-> (rx_reset == '0)); // R5

  AST_HELD_UNTIL_READY: assert property (@(posedge usr_clk) disable iff (!sys_rst_n)
    (!wide_data && !ready) |-> (rx_reset == '1)); // R1
endmodule

bind rxrst_seq rxrst_seq_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .ref_clk(ref_clk), .usr_clk(usr_clk), .sys_rst_n(sys_rst_n),
  .digital_mode(digital_mode), .wide_data(wide_data), .state(state),
  .all_full(all_full), .evt_enter_done(evt_enter_done),
  .evt_restart(evt_restart), .evt_lock_lost(evt_lock_lost),
  .rx_reset(rx_reset), .ready(ready)
);

// File: tb/rxrst_seq_tb.sv
module rxrst_seq_tb_top;
  localparam int LANES = 4;
  localparam int Q     = 16384;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] lock = '0;
  logic             dig = 1'b0;
  logic             wide = 1'b0;
  logic [LANES-1:0] rx_reset;
  logic             ready;

  always #2 clk = ~clk;   // 250 MHz, shared by both clock ports

  rxrst_seq #(.NUM_LANES(LANES), .QUAL_CYCLES(Q), .SYNC_STAGES(2)) dut_i (
    .ref_clk(clk), .usr_clk(clk), .sys_rst_n(rst_n), .lane_lock(lock),
    .digital_mode(dig), .wide_data(wide), .rx_reset(rx_reset), .ready(ready)
  );

  int    checks = 0;
  int    errors = 0;
  string phase_req = "R1";
  int    cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------- behavioural reference model ----------
  int         run_all;
  int         run_lane [LANES];
  bit         q_all [$];
  logic [5:0] hist_lane [LANES];
  bit         model_live = 1'b0;
  int         lim;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      run_all = 0;
      q_all.delete();
      for (int i = 0; i < LANES; i++) begin
        run_lane[i]  = 0;
        hist_lane[i] = '0;
      end
      model_live = 1'b0;
    end else begin
      model_live = 1'b1;
      lim = dig ? 1 : Q;
      run_all = (&lock) ? run_all + 1 : 0;
      q_all.push_back(run_all >= lim + 1);
      if (q_all.size() > 7) void'(q_all.pop_front());
      for (int i = 0; i < LANES; i++) begin
        run_lane[i]  = lock[i] ? run_lane[i] + 1 : 0;
        hist_lane[i] = {hist_lane[i][4:0], run_lane[i] >= lim + 1};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_live) begin
      bit               exp_ready;
      logic [LANES-1:0] exp_rst;
      exp_ready = (q_all.size() == 7) ? q_all[0] : 1'b0;
      for (int i = 0; i < LANES; i++)
        exp_rst[i] = wide ? ~hist_lane[i][5] : ~exp_ready;
      check(ready == exp_ready, {phase_req, " ready"}, int'(ready), int'(exp_ready));
      check(rx_reset == exp_rst, {phase_req, " rx_reset"}, int'(rx_reset), int'(exp_rst));
    end
  end

  // ---------- stimulus helpers ----------
  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset(input bit d, input bit w);
    @(negedge clk);
    rst_n = 1'b0;
    lock  = '0;
    dig   = d;
    wide  = w;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(10);
  endtask

  task automatic count_until_ready(output int n, output logic [LANES-1:0] prev_rst);
    n = 0;
    prev_rst = rx_reset;
    do begin
      prev_rst = rx_reset;
      @(negedge clk);
      n++;
    end while (!ready && n < Q + 100);
  endtask

  task automatic hold_watch(input int n, inout bit saw);
    repeat (n) begin
      @(negedge clk);
      if (ready || rx_reset != '1) saw = 1'b1;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    int               n;
    bit               saw;
    logic [LANES-1:0] prev;
    int               rise_c [LANES];
    int               fall_c [LANES];

    // R1: reset state
    wait_neg(3);
    check(rx_reset == '1, "R1 in reset rx_reset", int'(rx_reset), 15);
    check(ready == 1'b0, "R1 in reset ready", int'(ready), 0);
    rst_n = 1'b1;
    wait_neg(20);
    check(rx_reset == '1 && !ready, "R1 after release", int'(rx_reset), 15);

    // R3: reference-clock locks that drop after 128 and after exactly Q samples
    phase_req = "R3";
    saw = 1'b0;
    lock = '1;
    hold_watch(128, saw);
    lock = '0;
    hold_watch(40, saw);
    check(!saw, "R3 drop after 128", int'(saw), 0);
    lock = '1;
    hold_watch(Q, saw);
    lock = '0;
    hold_watch(12, saw);
    check(!saw, "R3 drop after exactly Q samples", int'(saw), 0);

    // R3/R2/R5: lock to data, release timing and lockstep
    lock = '1;
    count_until_ready(n, prev);
    check(n == Q + 7, "R2 R3 analog ready latency", n, Q + 7);
    check(prev == '1, "R5 all lanes held before release", int'(prev), 15);
    check(rx_reset == '0, "R5 all lanes released with ready", int'(rx_reset), 0);

    // R7: lock lost after done
    phase_req = "R7";
    wait_neg(20);
    lock[1] = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (ready && n < 50);
    check(n == 7, "R7 ready drop latency", n, 7);
    check(rx_reset == '1, "R7 all lanes back in reset", int'(rx_reset), 15);

    // R4: lane glitch during qualification restarts the window
    phase_req = "R4";
    lock = '1;
    wait_neg(5000);
    check(!ready, "R4 not ready mid window", int'(ready), 0);
    lock[2] = 1'b0;
    wait_neg(3);
    lock[2] = 1'b1;
    count_until_ready(n, prev);
    check(n == Q + 7, "R4 full window after glitch", n, Q + 7);

    // R6: digital mode, narrow width
    phase_req = "R6";
    apply_reset(1'b1, 1'b0);
    lock = '1;
    count_until_ready(n, prev);
    check(n == 8, "R6 digital ready latency", n, 8);
    check(rx_reset == '0 && prev == '1, "R5 digital lockstep", int'(rx_reset), 0);

    // R8: wide width, analog, staggered lanes
    phase_req = "R8";
    apply_reset(1'b0, 1'b1);
    for (int i = 0; i < LANES; i++) begin
      lock[i]   = 1'b1;
      rise_c[i] = cyc;
      fall_c[i] = -1;
      wait_neg(20);
    end
    n = 0;
    while ((fall_c[0] < 0 || fall_c[1] < 0 || fall_c[2] < 0 || fall_c[3] < 0) && n < Q + 200) begin
      for (int i = 0; i < LANES; i++)
        if (fall_c[i] < 0 && !rx_reset[i]) fall_c[i] = cyc;
      @(negedge clk);
      n++;
    end
    for (int i = 0; i < LANES; i++)
      check(fall_c[i] - rise_c[i] == Q + 6, "R8 analog per-lane release", fall_c[i] - rise_c[i], Q + 6);
    wait_neg(5);
    check(ready == 1'b1, "R8 group ready after last lane", int'(ready), 1);

    // R8: wide width, digital, staggered lanes
    apply_reset(1'b1, 1'b1);
    for (int i = 0; i < LANES; i++) begin
      lock[i]   = 1'b1;
      rise_c[i] = cyc;
      fall_c[i] = -1;
      wait_neg(1);
      for (int k = 0; k < 4; k++) begin
        for (int j = 0; j < LANES; j++)
          if (fall_c[j] < 0 && !rx_reset[j]) fall_c[j] = cyc;
        @(negedge clk);
      end
    end
    for (int k = 0; k < 20; k++) begin
      for (int j = 0; j < LANES; j++)
        if (fall_c[j] < 0 && !rx_reset[j]) fall_c[j] = cyc;
      @(negedge clk);
    end
    for (int i = 0; i < LANES; i++)
      check(fall_c[i] - rise_c[i] == 7, "R8 R6 digital per-lane release", fall_c[i] - rise_c[i], 7);

    wait_neg(5);
    summary();
    $finish;
  end
endmodule